// File: doc/BRIEF.md
# Smart-Card UART Receive Path

This block receives serial characters on a single line in one of two framings. In plain asynchronous mode a character is a start bit, eight data bits sent LSB first, and one or two stop bits. In smart-card mode a character is a start bit, eight data bits sent LSB first, and an even parity bit. A protocol-select input then sets how a parity error is handled. With T=1 selected the character is kept and an error is flagged. With T=0 selected the character is dropped and the receiver answers on the line with a low error pulse (NACK).

Bits are timed from a 16x oversampling tick. Completed characters go into a four-entry FIFO that the host reads with a strobe. A full FIFO can still accept one more finished character, which waits in the shift stage. Three sticky error flags (parity, framing, overrun) stay set until software writes 0 to the matching bit.

Top module: `sc_uart_rx`

## Requirements
- R1: A start bit is accepted only if the line is still low 8 ticks after the falling edge was first seen, so a low pulse shorter than half a bit stores nothing. Each further bit is sampled 16 ticks after the previous sample, and data bits arrive LSB first.
- R2: In smart-card mode with t1_mode_i=1, a character whose nine bits (data plus parity) hold an odd number of ones is still stored and sets par_err_o. err_drive_o stays 0.
- R3: In smart-card mode with t1_mode_i=0, a character with bad parity is not stored and par_err_o is not set. err_drive_o is 1 for exactly 24 ticks, starting 16 ticks after the parity sample, which is half a bit after the parity bit ends.
- R4: In smart-card mode with t1_mode_i=0, a character with good parity is stored and err_drive_o stays 0.
- R5: In asynchronous mode, a first stop bit sampled as 0 sets frm_err_o and the character is still stored. With two_stop_i=1 the second stop bit is not checked.
- R6: The FIFO holds 4 characters in arrival order. valid_o is 1 while it is not empty, data_o shows the oldest character, and rd_i removes it.
- R7: A character completed while the FIFO is full is held in the shift stage. It enters the FIFO on the second clock after a read, and its parity and framing flags are applied at that moment.
- R8: A character completed while another is already held overwrites the held one, sets ovr_err_o, and reception continues.
- R9: While flag_wr_i=1, a 0 in flag_wdata_i bit 0, bit 1 or bit 2 clears par_err_o, frm_err_o or ovr_err_o respectively. A 1 in any of these bits leaves that flag unchanged.
- R10: While rx_en_i=0 the receiver is idle, and the FIFO and the held character are discarded (valid_o=0 from the next clock).
- R11: After reset valid_o, err_drive_o and all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receive enable; low flushes the FIFO |
| card_mode_i | input | 1 | 1 = smart-card framing, 0 = asynchronous |
| t1_mode_i | input | 1 | Smart-card protocol: 1 = T=1, 0 = T=0 |
| two_stop_i | input | 1 | Asynchronous mode: two stop bits |
| tick_i | input | 1 | 16x oversampling tick, one clock wide |
| rx_i | input | 1 | Serial line level |
| err_drive_o | output | 1 | 1 = pull the line low (T=0 NACK) |
| rd_i | input | 1 | Read strobe, pops the oldest character |
| data_o | output | 8 | Oldest character in the FIFO |
| valid_o | output | 1 | FIFO not empty |
| flag_wr_i | input | 1 | Flag write strobe |
| flag_wdata_i | input | 3 | Flag write data; a 0 bit clears that flag |
| par_err_o | output | 1 | Sticky parity error |
| frm_err_o | output | 1 | Sticky framing error |
| ovr_err_o | output | 1 | Sticky overrun error |

## Verification
Assertions check on every cycle that the three flags only fall under a matching zero write, and that the NACK drive appears only in T=0 smart-card mode. They also check that an overrun only rises while a held character meets a full FIFO, that a disabled receiver shows an empty FIFO, and that stored data does not vanish without a read. The bench scenarios are needed for the end-to-end facts: the NACK width and position, dropping versus keeping of bad-parity characters, the unchecked second stop bit, the glitch filter, and which character survives an overwrite of the held slot.

// File: rtl/sc_uart_rx_pkg.sv
package sc_uart_rx_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2, S_GAP, S_NWAIT, S_NACK
  } rx_state_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              par_err;
    logic              frm_err;
  } rx_char_t;
endpackage

// File: rtl/sc_uart_rx_sampler.sv
module sc_uart_rx_sampler
  import sc_uart_rx_pkg::*;
#(
  parameter int OSR        = 16,
  parameter int NACK_TICKS = 24
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  logic     card_mode_i,
  input  logic     t1_mode_i,
  input  logic     two_stop_i,
  input  logic     tick_i,
  input  logic     rx_i,
  output logic     char_vld_o,
  output rx_char_t char_o,
  output logic     nack_o
);
  localparam int CNT_MAX = (NACK_TICKS > OSR) ? NACK_TICKS : OSR;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int BIT_W   = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(OSR - 1);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] NACK_LAST = CNT_W'(NACK_TICKS - 1);
  localparam logic [BIT_W-1:0] DATA_LAST = BIT_W'(DATA_W - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] sh_q;
  logic [1:0]        sync_q;
  logic              char_vld_q;
  rx_char_t          char_q;
  logic              rx_s, bit_end, par_bad;

  assign rx_s    = sync_q[1];
  assign bit_end = (cnt_q == BIT_LAST);
  assign par_bad = ^{sh_q, rx_s};  // even parity over data + parity bit

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      cnt_q      <= '0;
      bit_q      <= '0;
      sh_q       <= '0;
      sync_q     <= 2'b11;
      char_vld_q <= 1'b0;
      char_q     <= '0;
    end else begin
      char_vld_q <= 1'b0;
      sync_q     <= {sync_q[0], rx_i};
      if (!en_i) begin
        state_q <= S_IDLE;
        cnt_q   <= '0;
      end else if (tick_i) begin
        cnt_q <= cnt_q + 1'b1;
        unique case (state_q)
          S_IDLE: begin
            cnt_q <= '0;
            if (!rx_s) state_q <= S_START;
          end
          S_START: if (cnt_q == HALF_LAST) begin
            cnt_q   <= '0;
            bit_q   <= '0;
            state_q <= rx_s ? S_IDLE : S_DATA;
          end
          S_DATA: if (bit_end) begin
            cnt_q <= '0;
            sh_q  <= {rx_s, sh_q[DATA_W-1:1]};
            bit_q <= bit_q + 1'b1;
            if (bit_q == DATA_LAST) state_q <= card_mode_i ? S_PAR : S_STOP1;
          end
          S_PAR: if (bit_end) begin
            cnt_q <= '0;
            if (par_bad && !t1_mode_i) begin
              state_q <= S_NWAIT;  // T=0: drop and answer with NACK
            end else begin
              char_vld_q     <= 1'b1;
              char_q.data    <= sh_q;
              char_q.par_err <= par_bad;
              char_q.frm_err <= 1'b0;
              state_q        <= S_GAP;
            end
          end
          S_STOP1: if (bit_end) begin
            cnt_q          <= '0;
            char_vld_q     <= 1'b1;
            char_q.data    <= sh_q;
            char_q.par_err <= 1'b0;
            char_q.frm_err <= !rx_s;
            state_q        <= two_stop_i ? S_STOP2 : S_GAP;
          end
          S_STOP2: if (bit_end) begin
            cnt_q   <= '0;
            state_q <= S_GAP;  // second stop bit not checked
          end
          S_GAP: if (cnt_q == HALF_LAST) begin
            cnt_q   <= '0;
            state_q <= S_IDLE;
          end
          S_NWAIT: if (bit_end) begin
            cnt_q   <= '0;
            state_q <= S_NACK;
          end
          S_NACK: if (cnt_q == NACK_LAST) begin
            cnt_q   <= '0;
            state_q <= S_IDLE;
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  assign char_vld_o = char_vld_q;
  assign char_o     = char_q;
  assign nack_o     = (state_q == S_NACK);
endmodule

// File: rtl/sc_uart_rx_fifo.sv
module sc_uart_rx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == PTR_LAST) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == PTR_LAST) ? '0 : rd_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wr_q] <= wdata_i;
  end

  assign rdata_o = mem_q[rd_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_FULL);
endmodule

// File: rtl/sc_uart_rx_flags.sv
module sc_uart_rx_flags #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] flags_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 flag_q <= 1'b0;
      else if (set_i[i])           flag_q <= 1'b1;  // set wins over clear
      else if (wr_i && !wdata_i[i]) flag_q <= 1'b0;
    end
    assign flags_o[i] = flag_q;
  end
endmodule

// File: rtl/sc_uart_rx.sv
module sc_uart_rx
  import sc_uart_rx_pkg::*;
#(
  parameter int OSR        = 16,
  parameter int NACK_TICKS = 24,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic              card_mode_i,
  input  logic              t1_mode_i,
  input  logic              two_stop_i,
  input  logic              tick_i,
  input  logic              rx_i,
  output logic              err_drive_o,
  input  logic              rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  input  logic              flag_wr_i,
  input  logic [2:0]        flag_wdata_i,
  output logic              par_err_o,
  output logic              frm_err_o,
  output logic              ovr_err_o
);
  rx_char_t   new_char, hold_q, push_char;
  logic       new_vld, hold_valid_q;
  logic       fifo_full, fifo_empty, push, pop, ovr_set;
  logic [2:0] flag_set, flags;

  sc_uart_rx_sampler #(.OSR(OSR), .NACK_TICKS(NACK_TICKS)) u_smp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (rx_en_i),
    .card_mode_i (card_mode_i),
    .t1_mode_i   (t1_mode_i),
    .two_stop_i  (two_stop_i),
    .tick_i      (tick_i),
    .rx_i        (rx_i),
    .char_vld_o  (new_vld),
    .char_o      (new_char),
    .nack_o      (err_drive_o)
  );

  // held character has priority into the FIFO
  assign push      = rx_en_i && !fifo_full && (hold_valid_q || new_vld);
  assign push_char = hold_valid_q ? hold_q : new_char;
  assign pop       = rd_i && !fifo_empty;
  assign ovr_set   = rx_en_i && new_vld && hold_valid_q && fifo_full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_valid_q <= 1'b0;
      hold_q       <= '0;
    end else if (!rx_en_i) begin
      hold_valid_q <= 1'b0;
    end else if (new_vld && (hold_valid_q || fifo_full)) begin
      hold_q       <= new_char;
      hold_valid_q <= 1'b1;
    end else if (push) begin
      hold_valid_q <= 1'b0;
    end
  end

  sc_uart_rx_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (!rx_en_i),
    .push_i  (push),
    .wdata_i (push_char.data),
    .pop_i   (pop),
    .rdata_o (data_o),
    .empty_o (fifo_empty),
    .full_o  (fifo_full)
  );

  assign flag_set = {ovr_set, push && push_char.frm_err, push && push_char.par_err};

  sc_uart_rx_flags #(.N(3)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (flag_set),
    .wr_i    (flag_wr_i),
    .wdata_i (flag_wdata_i),
    .flags_o (flags)
  );

  assign valid_o   = !fifo_empty;
  assign par_err_o = flags[0];
  assign frm_err_o = flags[1];
  assign ovr_err_o = flags[2];
endmodule

// File: rtl/sc_uart_rx_chk.sv
module sc_uart_rx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rx_en_i,
  input logic       card_mode_i,
  input logic       t1_mode_i,
  input logic       rd_i,
  input logic       valid_o,
  input logic       err_drive_o,
  input logic       flag_wr_i,
  input logic [2:0] flag_wdata_i,
  input logic       par_err_o,
  input logic       frm_err_o,
  input logic       ovr_err_o,
  input logic       hold_valid_q,
  input logic       fifo_full
);
  // R3
  nack_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_drive_o |-> (card_mode_i && !t1_mode_i));

  // R9
  par_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_err_o && !(flag_wr_i && !flag_wdata_i[0])) |=> par_err_o);

  // R9
  frm_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_err_o && !(flag_wr_i && !flag_wdata_i[1])) |=> frm_err_o);

  // R9
  ovr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_err_o && !(flag_wr_i && !flag_wdata_i[2])) |=> ovr_err_o);

  // R8
  ovr_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_err_o) |-> $past(hold_valid_q && fifo_full));

  // R10
  flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> !valid_o);

  // R6
  keep_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !rd_i && rx_en_i) |=> valid_o);
endmodule

bind sc_uart_rx sc_uart_rx_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rx_en_i      (rx_en_i),
  .card_mode_i  (card_mode_i),
  .t1_mode_i    (t1_mode_i),
  .rd_i         (rd_i),
  .valid_o      (valid_o),
  .err_drive_o  (err_drive_o),
  .flag_wr_i    (flag_wr_i),
  .flag_wdata_i (flag_wdata_i),
  .par_err_o    (par_err_o),
  .frm_err_o    (frm_err_o),
  .ovr_err_o    (ovr_err_o),
  .hold_valid_q (hold_valid_q),
  .fifo_full    (fifo_full)
);

// File: tb/sc_uart_rx_tb.sv
module sc_uart_rx_tb;
  localparam int CLK_P    = 10;
  localparam int TICK_DIV = 4;
  localparam int BIT_CLKS = 16 * TICK_DIV;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       rx_en_i = 1'b0, card_mode_i = 1'b0, t1_mode_i = 1'b0, two_stop_i = 1'b0;
  logic       tick_i = 1'b0, tx_lvl = 1'b1, rd_i = 1'b0, flag_wr_i = 1'b0;
  logic [2:0] flag_wdata_i = 3'b111;
  logic       rx_i, err_drive_o, valid_o, par_err_o, frm_err_o, ovr_err_o;
  logic [7:0] data_o;

  assign rx_i = tx_lvl & ~err_drive_o;  // open-drain line

  sc_uart_rx u_dut (
    .clk_i, .rst_ni, .rx_en_i, .card_mode_i, .t1_mode_i, .two_stop_i, .tick_i,
    .rx_i, .err_drive_o, .rd_i, .data_o, .valid_o, .flag_wr_i, .flag_wdata_i,
    .par_err_o, .frm_err_o, .ovr_err_o
  );

  always #(CLK_P / 2) clk_i = ~clk_i;

  int tick_cnt = 0;
  always @(posedge clk_i) begin
    tick_cnt <= (tick_cnt == TICK_DIV - 1) ? 0 : tick_cnt + 1;
    tick_i   <= (tick_cnt == TICK_DIV - 1);
  end

  int n_chk = 0, n_fail = 0;
  longint cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  // reference model
  logic [7:0] exp_q[$];
  bit exp_par = 0, exp_frm = 0, exp_ovr = 0;
  bit hold_v = 0, hold_p = 0, hold_f = 0;
  logic [7:0] hold_d = '0;
  bit cmp_en = 0, nack_ok = 0;
  int nack_clks = 0;
  longint nack_first = -1, par_start = 0;

  task automatic chk_eq(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    chk_eq(req, "valid", valid_o, exp_q.size() != 0);
    if (exp_q.size() != 0) chk_eq(req, "data", data_o, exp_q[0]);
    chk_eq(req, "par flag", par_err_o, exp_par);
    chk_eq(req, "frm flag", frm_err_o, exp_frm);
    chk_eq(req, "ovr flag", ovr_err_o, exp_ovr);
  endtask

  function automatic void m_rx(input logic [7:0] d, input bit p, input bit f);
    if (hold_v) begin
      hold_d = d; hold_p = p; hold_f = f; exp_ovr = 1;
    end else if (exp_q.size() < 4) begin
      exp_q.push_back(d); exp_par |= p; exp_frm |= f;
    end else begin
      hold_v = 1; hold_d = d; hold_p = p; hold_f = f;
    end
  endfunction

  function automatic void m_read();
    if (exp_q.size() != 0) void'(exp_q.pop_front());
    if (hold_v) begin
      exp_q.push_back(hold_d); exp_par |= hold_p; exp_frm |= hold_f; hold_v = 0;
    end
  endfunction

  always @(posedge clk_i) begin
    if (cmp_en) compare_all("R6");
    if (rst_ni && !nack_ok) chk_eq("R2", "line drive", err_drive_o, 0);
  end

  always @(negedge clk_i) begin
    if (err_drive_o) begin
      nack_clks++;
      if (nack_first < 0) nack_first = cyc;
    end
  end

  task automatic send_bit(input logic b);
    tx_lvl = b;
    repeat (BIT_CLKS) @(negedge clk_i);
  endtask

  task automatic send_async(input logic [7:0] d, input logic s1, input logic s2);
    cmp_en = 0;
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
    send_bit(s1);
    if (two_stop_i) send_bit(s2);
    tx_lvl = 1'b1;
    repeat (2 * BIT_CLKS) @(negedge clk_i);
  endtask

  task automatic send_iso(input logic [7:0] d, input bit flip);
    cmp_en = 0;
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
    par_start = cyc;
    send_bit((^d) ^ flip);
    tx_lvl = 1'b1;
    repeat (4 * BIT_CLKS) @(negedge clk_i);
  endtask

  task automatic rd_one();
    cmp_en = 0;
    rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
    m_read();
    repeat (2) @(negedge clk_i);
    cmp_en = 1;
  endtask

  task automatic rd_expect(input string req, input logic [7:0] v);
    chk_eq(req, "valid before read", valid_o, 1);
    chk_eq(req, "read data", data_o, v);
    rd_one();
  endtask

  task automatic clr(input logic [2:0] w);
    flag_wr_i = 1'b1; flag_wdata_i = w;
    @(negedge clk_i);
    flag_wr_i = 1'b0; flag_wdata_i = 3'b111;
    if (!w[0]) exp_par = 0;
    if (!w[1]) exp_frm = 0;
    if (!w[2]) exp_ovr = 0;
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R11 reset state
    chk_eq("R11", "valid", valid_o, 0);
    chk_eq("R11", "nack", err_drive_o, 0);
    chk_eq("R11", "flags", {par_err_o, frm_err_o, ovr_err_o}, 0);
    rx_en_i = 1'b1;
    repeat (4) @(negedge clk_i);
    cmp_en = 1;

    // R1 / R6: plain frames, LSB first, in order
    send_async(8'hA5, 1, 1); m_rx(8'hA5, 0, 0); cmp_en = 1;
    send_async(8'h3C, 1, 1); m_rx(8'h3C, 0, 0); cmp_en = 1;
    compare_all("R1");
    rd_expect("R6", 8'hA5);
    rd_expect("R6", 8'h3C);
    chk_eq("R6", "empty after reads", valid_o, 0);

    // R5 framing error, stored
    send_async(8'h81, 0, 1); m_rx(8'h81, 0, 1); cmp_en = 1;
    chk_eq("R5", "frm flag", frm_err_o, 1);
    chk_eq("R5", "stored", data_o, 8'h81);

    // R9 write-one no effect, write-zero clears
    clr(3'b111);
    chk_eq("R9", "frm after write 1", frm_err_o, 1);
    clr(3'b101);
    chk_eq("R9", "frm after write 0", frm_err_o, 0);
    rd_one();

    // R5 two stop bits: only first checked
    two_stop_i = 1'b1;
    send_async(8'h5A, 1, 0); m_rx(8'h5A, 0, 0); cmp_en = 1;
    chk_eq("R5", "second stop ignored", frm_err_o, 0);
    send_async(8'hC3, 0, 1); m_rx(8'hC3, 0, 1); cmp_en = 1;
    chk_eq("R5", "first stop checked", frm_err_o, 1);
    rd_one(); rd_one();
    clr(3'b000);
    two_stop_i = 1'b0;

    // R2 T=1
    card_mode_i = 1'b1; t1_mode_i = 1'b1;
    nack_clks = 0;
    send_iso(8'h6E, 0); m_rx(8'h6E, 0, 0); cmp_en = 1;
    chk_eq("R2", "good parity flag", par_err_o, 0);
    send_iso(8'h91, 1); m_rx(8'h91, 1, 0); cmp_en = 1;
    chk_eq("R2", "bad parity flag", par_err_o, 1);
    chk_eq("R2", "no nack", nack_clks, 0);
    rd_expect("R2", 8'h6E);
    rd_expect("R2", 8'h91);
    clr(3'b000);

    // R3 / R4 T=0
    t1_mode_i = 1'b0;
    nack_ok = 1; nack_clks = 0; nack_first = -1;
    send_iso(8'h47, 1); cmp_en = 1;
    chk_eq("R3", "nack width", nack_clks, 24 * TICK_DIV);
    chk_eq("R3", "nack offset in window",
           (nack_first - par_start >= 88) && (nack_first - par_start <= 112), 1);
    chk_eq("R3", "dropped", valid_o, 0);
    chk_eq("R3", "no par flag", par_err_o, 0);
    nack_clks = 0;
    send_iso(8'hB2, 0); m_rx(8'hB2, 0, 0); cmp_en = 1;
    chk_eq("R4", "no nack", nack_clks, 0);
    rd_expect("R4", 8'hB2);
    nack_ok = 0;
    card_mode_i = 1'b0;

    // R7 / R8 hold and overrun
    for (int i = 0; i < 5; i++) begin
      send_async(8'h10 + 8'(i), 1, 1); m_rx(8'h10 + 8'(i), 0, 0); cmp_en = 1;
    end
    chk_eq("R7", "no overrun on fifth", ovr_err_o, 0);
    rd_expect("R7", 8'h10);
    send_async(8'h30, 1, 1); m_rx(8'h30, 0, 0); cmp_en = 1;
    chk_eq("R8", "held only, no overrun", ovr_err_o, 0);
    send_async(8'h31, 1, 1); m_rx(8'h31, 0, 0); cmp_en = 1;
    chk_eq("R8", "overrun flag", ovr_err_o, 1);
    rd_expect("R7", 8'h11);
    rd_expect("R7", 8'h12);
    rd_expect("R7", 8'h13);
    rd_expect("R7", 8'h14);
    rd_expect("R8", 8'h31);
    chk_eq("R8", "empty", valid_o, 0);
    clr(3'b000);

    // R10 disable flushes
    send_async(8'h61, 1, 1); m_rx(8'h61, 0, 0); cmp_en = 1;
    send_async(8'h62, 1, 1); m_rx(8'h62, 0, 0); cmp_en = 1;
    cmp_en = 0;
    rx_en_i = 1'b0;
    repeat (3) @(negedge clk_i);
    exp_q.delete(); hold_v = 0;
    chk_eq("R10", "flushed", valid_o, 0);
    rx_en_i = 1'b1;
    repeat (2) @(negedge clk_i);
    cmp_en = 1;
    send_async(8'h77, 1, 1); m_rx(8'h77, 0, 0); cmp_en = 1;
    rd_expect("R10", 8'h77);

    // R1 short glitch is not a start bit
    tx_lvl = 1'b0;
    repeat (4 * TICK_DIV) @(negedge clk_i);
    tx_lvl = 1'b1;
    repeat (3 * BIT_CLKS) @(negedge clk_i);
    chk_eq("R1", "glitch ignored", valid_o, 0);

    cmp_en = 0;
    finish_run();
  end
endmodule